// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a RISC core in which the 32 architectural register numbers are translated to physical storage through a current window pointer. Eight global registers sit outside any window. The remaining numbers address a window made of eight private locals and two groups of eight registers shared with the windows on either side. The outs of one window are the very same storage as the ins of the next window that a save moves to. This lets a caller hand arguments to a callee without copying them.

A save request moves the pointer down by one and a restore request moves it up by one, both wrapping around the ring of windows. A per-window invalid mask, loaded by software through its own port, guards the moves. A move into a marked window is refused, the pointer stays put, and a one-cycle overflow (save) or underflow (restore) trap pulse is raised instead. The ring closes on itself, so when every window is in use the newest window's outs land on the oldest window's ins. Software therefore has one window fewer than are built.

The core reads two operands combinationally through the current mapping and writes one result per cycle. Trap service, spilling and filling windows to memory, and the rest of the processor state are handled outside this block.

Top module: `regwin_file`

## Requirements
- R1: After reset the window pointer is 0, the invalid mask is all zeros, both trap outputs are low and every register reads as zero.
- R2: Register number 0 always reads as zero on both read ports, and a write addressed to it has no effect.
- R3: A save request (save high, restore low) whose target window ((pointer−1) mod NWIN) has its mask bit clear sets the pointer to that target on the next clock, so pointer 0 wraps to NWIN−1.
- R4: A restore request (restore high, save low) whose target window ((pointer+1) mod NWIN) has its mask bit clear sets the pointer to that target on the next clock, so NWIN−1 wraps to 0.
- R5: A save request whose target window is marked in the mask leaves the pointer unchanged and drives the overflow trap high for exactly the one cycle after the request.
- R6: A restore request whose target window is marked in the mask leaves the pointer unchanged and drives the underflow trap high for exactly the one cycle after the request.
- R7: Register numbers 8 to 15 (outs) of window w name the same storage as numbers 24 to 31 (ins) of window (w−1) mod NWIN, including the wrap from window 0 to window NWIN−1.
- R8: Register numbers 16 to 23 (locals) of each window are private: a write in one window is not visible through the locals of any other window.
- R9: Register numbers 1 to 7 (globals) name the same storage whatever the window pointer is.
- R10: A write issued in the same cycle as a save or restore lands in the window selected by the pointer value before the move.
- R11: When the mask load strobe is high, the whole mask takes the supplied value on the next clock. A save or restore in that same cycle is checked against the mask value held before the load.
- R12: Save and restore asserted together are ignored: the pointer does not move and neither trap is raised.
- R13: The two read ports are independent: each returns, in the same cycle, the register its own address selects through the current pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs1_addr | input | 5 | Architectural register number for read port 1 |
| rs1_data | output | XLEN | Read data for port 1 (combinational) |
| rs2_addr | input | 5 | Architectural register number for read port 2 |
| rs2_data | output | XLEN | Read data for port 2 (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move the pointer down one window |
| restore_req | input | 1 | Move the pointer up one window |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_wdata | input | NWIN | New mask value, bit w marks window w |
| cwp | output | CWPW | Current window pointer |
| mask | output | NWIN | Current invalid-window mask |
| ovf_trap | output | 1 | One-cycle overflow trap pulse |
| unf_trap | output | 1 | One-cycle underflow trap pulse |

## Verification
The assertions take every input to be a clean, known level at each rising edge. They place no limit on combining save, restore, mask loads and writes: they state the outcome of each combination, simultaneous save and restore included. The stimulus changes inputs only on falling edges and keeps the inputs idle while reset is held. After directed sequences for wraps, sharing and refused moves, it mixes random saves, restores, occasional mask loads and writes to random register numbers. The random phase covers the case where a full ring makes the newest outs alias the oldest ins.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef logic [4:0] areg_t;

    // Register number bits [4:3] choose the group; the order is fixed
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;

    localparam int unsigned GRP_SIZE  = 8;
    localparam int unsigned WIN_SPAN  = 2 * GRP_SIZE;

    function automatic grp_e grp_of(input areg_t a);
        return grp_e'(a[4:3]);
    endfunction

endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CWPW = 3,
    parameter int unsigned PW   = 8
) (
    input  logic [CWPW-1:0] cwp,
    input  areg_t           areg,
    output logic [PW-1:0]   phys
);

    logic [CWPW-1:0] prev_win;
    int unsigned     idx;

    always_comb begin
        prev_win = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - 1'b1;
        unique case (grp_of(areg))
            GRP_GLOBAL: idx = int'(areg[2:0]);
            GRP_OUT:    idx = GRP_SIZE + WIN_SPAN * int'(prev_win) + GRP_SIZE + int'(areg[2:0]);
            GRP_LOCAL:  idx = GRP_SIZE + WIN_SPAN * int'(cwp) + int'(areg[2:0]);
            default:    idx = GRP_SIZE + WIN_SPAN * int'(cwp) + GRP_SIZE + int'(areg[2:0]);
        endcase
        phys = PW'(idx);
    end

endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CWPW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            mask_we,
    input  logic [NWIN-1:0] mask_wdata,
    output logic [CWPW-1:0] cwp,
    output logic [NWIN-1:0] mask,
    output logic            ovf_trap,
    output logic            unf_trap
);

    typedef struct packed {
        logic [CWPW-1:0] cwp;
        logic [NWIN-1:0] mask;
        logic            ovf;
        logic            unf;
    } ctl_t;

    ctl_t            st_d, st_q;
    logic [CWPW-1:0] dn_win, up_win;

    always_comb begin
        dn_win = (st_q.cwp == '0) ? CWPW'(NWIN - 1) : st_q.cwp - 1'b1;
        up_win = (st_q.cwp == CWPW'(NWIN - 1)) ? '0 : st_q.cwp + 1'b1;

        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        // Moves are judged against the mask held before any load this cycle
        if (save_req && !restore_req) begin
            if (st_q.mask[dn_win]) st_d.ovf = 1'b1;
            else                   st_d.cwp = dn_win;
        end else if (restore_req && !save_req) begin
            if (st_q.mask[up_win]) st_d.unf = 1'b1;
            else                   st_d.cwp = up_win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp      = st_q.cwp;
    assign mask     = st_q.mask;
    assign ovf_trap = st_q.ovf;
    assign unf_trap = st_q.unf;

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NPHYS = 136,
    parameter int unsigned PW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [PW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [PW-1:0]   raddr_a,
    output logic [XLEN-1:0] rdata_a,
    input  logic [PW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_b
);

    // Entry 0 is the hard zero: reset and never written
    logic [XLEN-1:0] regs_q [NPHYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NPHYS); i++) regs_q[i] <= '0;
        end else if (we && (waddr != '0) && (int'(waddr) < int'(NPHYS))) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rdata_a = (int'(raddr_a) < int'(NPHYS)) ? regs_q[raddr_a] : '0;
    assign rdata_b = (int'(raddr_b) < int'(NPHYS)) ? regs_q[raddr_b] : '0;

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned CWPW  = (NWIN > 2) ? $clog2(NWIN) : 1,
    localparam int unsigned NPHYS = GRP_SIZE + WIN_SPAN * NWIN,
    localparam int unsigned PW    = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rs1_addr,
    output logic [XLEN-1:0] rs1_data,
    input  logic [4:0]      rs2_addr,
    output logic [XLEN-1:0] rs2_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            mask_we,
    input  logic [NWIN-1:0] mask_wdata,
    output logic [CWPW-1:0] cwp,
    output logic [NWIN-1:0] mask,
    output logic            ovf_trap,
    output logic            unf_trap
);

    localparam int unsigned NPORT = 3;

    areg_t         port_areg [NPORT];
    logic [PW-1:0] port_phys [NPORT];

    assign port_areg[0] = rs1_addr;
    assign port_areg[1] = rs2_addr;
    assign port_areg[2] = wr_addr;

    regwin_ctl #(.NWIN(NWIN), .CWPW(CWPW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .cwp         (cwp),
        .mask        (mask),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    // The write uses the registered pointer, i.e. the value before any move
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        regwin_map #(.NWIN(NWIN), .CWPW(CWPW), .PW(PW)) u_map (
            .cwp  (cwp),
            .areg (port_areg[p]),
            .phys (port_phys[p])
        );
    end

    regwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (port_phys[2]),
        .wdata   (wr_data),
        .raddr_a (port_phys[0]),
        .rdata_a (rs1_data),
        .raddr_b (port_phys[1]),
        .rdata_b (rs2_data)
    );

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned XLEN = 32,
    parameter int unsigned CWPW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      rs1_addr,
    input logic [XLEN-1:0] rs1_data,
    input logic [4:0]      rs2_addr,
    input logic [XLEN-1:0] rs2_data,
    input logic            save_req,
    input logic            restore_req,
    input logic            mask_we,
    input logic [NWIN-1:0] mask_wdata,
    input logic [CWPW-1:0] cwp,
    input logic [NWIN-1:0] mask,
    input logic            ovf_trap,
    input logic            unf_trap
);

    logic [CWPW-1:0] tgt_dn, tgt_up;
    assign tgt_dn = (cwp == '0) ? CWPW'(NWIN - 1) : cwp - 1'b1;
    assign tgt_up = (cwp == CWPW'(NWIN - 1)) ? '0 : cwp + 1'b1;

    assert_r0_port1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_addr == 5'd0) |-> (rs1_data == '0));

    assert_r0_port2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs2_addr == 5'd0) |-> (rs2_data == '0));

    assert_save_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && !mask[tgt_dn]) |=> (cwp == $past(tgt_dn)) && !ovf_trap);

    assert_restore_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !mask[tgt_up]) |=> (cwp == $past(tgt_up)) && !unf_trap);

    assert_no_overflow_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && mask[tgt_dn]) |=> ovf_trap && $stable(cwp));

    assert_no_underflow_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && mask[tgt_up]) |=> unf_trap && $stable(cwp));

    assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_trap) |-> $past(save_req));

    assert_traps_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_trap, unf_trap}));

    assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_wdata)));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));

    assert_both_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> $stable(cwp) && !ovf_trap && !unf_trap);

endmodule

bind regwin_file regwin_chk #(.NWIN(NWIN), .XLEN(XLEN), .CWPW(CWPW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rs1_addr    (rs1_addr),
    .rs1_data    (rs1_data),
    .rs2_addr    (rs2_addr),
    .rs2_data    (rs2_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .cwp         (cwp),
    .mask        (mask),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/regwin_file_tb.sv
module regwin_file_tb;

    localparam int NW   = 8;
    localparam int XL   = 32;
    localparam int CW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rs1_addr = '0, rs2_addr = '0, wr_addr = '0;
    logic [XL-1:0] rs1_data, rs2_data, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, mask_we = 1'b0;
    logic [NW-1:0] mask_wdata = '0;
    logic [CW-1:0] cwp;
    logic [NW-1:0] mask;
    logic          ovf_trap, unf_trap;

    always #4 clk = ~clk;

    regwin_file #(.NWIN(NW), .XLEN(XL)) u_dut (
        .clk, .rst_n, .rs1_addr, .rs1_data, .rs2_addr, .rs2_data,
        .wr_en, .wr_addr, .wr_data, .save_req, .restore_req,
        .mask_we, .mask_wdata, .cwp, .mask, .ovf_trap, .unf_trap
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Behavioural reference: globals, per-window locals and ins
    logic [XL-1:0] m_g   [8];
    logic [XL-1:0] m_loc [NW][8];
    logic [XL-1:0] m_in  [NW][8];
    int            m_cwp;
    logic [NW-1:0] m_mask;
    bit            m_ovf, m_unf;

    task automatic check(string tag, logic [XL-1:0] act, logic [XL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [XL-1:0] m_read(int w, int a);
        if (a == 0)      return '0;
        else if (a < 8)  return m_g[a];
        else if (a < 16) return m_in[(w + NW - 1) % NW][a - 8];
        else if (a < 24) return m_loc[w][a - 16];
        else             return m_in[w][a - 24];
    endfunction

    task automatic m_write(int w, int a, logic [XL-1:0] d);
        if (a == 0)      ;
        else if (a < 8)  m_g[a] = d;
        else if (a < 16) m_in[(w + NW - 1) % NW][a - 8] = d;
        else if (a < 24) m_loc[w][a - 16] = d;
        else             m_in[w][a - 24] = d;
    endtask

    task automatic m_reset();
        for (int i = 0; i < 8; i++) m_g[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin
                m_loc[w][i] = '0;
                m_in[w][i]  = '0;
            end
        m_cwp = 0; m_mask = '0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic m_step();
        int dn, up;
        dn = (m_cwp + NW - 1) % NW;
        up = (m_cwp + 1) % NW;
        if (wr_en) m_write(m_cwp, int'(wr_addr), wr_data);
        m_ovf = 0; m_unf = 0;
        if (save_req && !restore_req) begin
            if (m_mask[dn]) m_ovf = 1; else m_cwp = dn;
        end else if (restore_req && !save_req) begin
            if (m_mask[up]) m_unf = 1; else m_cwp = up;
        end
        if (mask_we) m_mask = mask_wdata;
    endtask

    // One clock: drive at the falling edge, compare reads before the
    // rising edge and registered state just after it.
    task automatic cyc(bit we, int wa, logic [XL-1:0] wd, bit sv, bit rs,
                       bit mwe, logic [NW-1:0] mwd, int ra1, int ra2);
        @(negedge clk);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        save_req = sv; restore_req = rs;
        mask_we = mwe; mask_wdata = mwd;
        rs1_addr = 5'(ra1); rs2_addr = 5'(ra2);
        #1;
        check("R13 port1", rs1_data, m_read(m_cwp, ra1));
        check("R13 port2", rs2_data, m_read(m_cwp, ra2));
        @(posedge clk);
        m_step();
        #1;
        check("R3 pointer", XL'(cwp), XL'(m_cwp));
        check("R11 mask",   XL'(mask), XL'(m_mask));
        check("R5 ovf",     XL'(ovf_trap), XL'(m_ovf));
        check("R6 unf",     XL'(unf_trap), XL'(m_unf));
    endtask

    task automatic idle(int ra1 = 0, int ra2 = 0);
        cyc(0, 0, '0, 0, 0, 0, '0, ra1, ra2);
    endtask

    task automatic peek(string tag, int a, logic [XL-1:0] exp);
        idle(a, 0);
        check(tag, rs1_data, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 pointer", XL'(cwp), '0);
        check("R1 mask", XL'(mask), '0);
        check("R1 traps", XL'({ovf_trap, unf_trap}), '0);
        peek("R1 reg r5", 5, '0);
        peek("R1 reg r20", 20, '0);

        // R2: write to r0 ignored
        cyc(1, 0, 32'hDEAD_BEEF, 0, 0, 0, '0, 0, 0);
        idle(0, 0);
        check("R2 r0 port1", rs1_data, '0);
        check("R2 r0 port2", rs2_data, '0);
        cyc(1, 1, 32'h0000_0011, 0, 0, 0, '0, 0, 0);

        // R7 / R3: out of window 0 becomes in of window NW-1 after save
        cyc(1, 8, 32'h0000_00A0, 0, 0, 0, '0, 0, 0);
        cyc(0, 0, '0, 1, 0, 0, '0, 0, 0);
        check("R3 wrap to top", XL'(cwp), XL'(NW - 1));
        peek("R7 out->in alias", 24, 32'h0000_00A0);
        peek("R9 global shared", 1, 32'h0000_0011);
        cyc(1, 16, 32'h0000_0077, 0, 0, 0, '0, 0, 0);

        // R4: wrap back to 0; R8: locals private
        cyc(0, 0, '0, 0, 1, 0, '0, 0, 0);
        check("R4 wrap to zero", XL'(cwp), '0);
        peek("R8 local private", 16, '0);
        peek("R7 out kept", 8, 32'h0000_00A0);

        // R10: write in the save cycle lands in the old window
        cyc(1, 17, 32'h0000_0055, 1, 0, 0, '0, 0, 0);
        peek("R10 new window untouched", 17, '0);
        cyc(0, 0, '0, 0, 1, 0, '0, 0, 0);
        peek("R10 old window written", 17, 32'h0000_0055);

        // R11: mask load and save in one cycle use the old mask
        cyc(0, 0, '0, 1, 0, 1, NW'(1) << (NW - 1), 0, 0);
        check("R11 old mask used", XL'(cwp), XL'(NW - 1));
        check("R11 mask loaded", XL'(mask), XL'(NW'(1) << (NW - 1)));
        cyc(0, 0, '0, 0, 1, 0, '0, 0, 0);

        // R5: save into the marked window is refused
        cyc(0, 0, '0, 1, 0, 0, '0, 0, 0);
        check("R5 ovf pulse", XL'(ovf_trap), 1);
        check("R5 pointer held", XL'(cwp), '0);
        idle();
        check("R5 pulse one cycle", XL'(ovf_trap), 0);

        // R6: restore into a marked window is refused
        cyc(0, 0, '0, 0, 0, 1, NW'(2), 0, 0);
        cyc(0, 0, '0, 0, 1, 0, '0, 0, 0);
        check("R6 unf pulse", XL'(unf_trap), 1);
        check("R6 pointer held", XL'(cwp), '0);
        idle();
        check("R6 pulse one cycle", XL'(unf_trap), 0);

        // R12: both strobes ignored
        cyc(0, 0, '0, 1, 1, 1, '0, 0, 0);
        check("R12 no move", XL'(cwp), '0);
        check("R12 no trap", XL'({ovf_trap, unf_trap}), '0);

        // R7: walk the full ring so the newest outs meet the oldest ins
        for (int i = 0; i < NW - 1; i++) cyc(0, 0, '0, 1, 0, 0, '0, 0, 0);
        cyc(1, 9, 32'h0000_0C0C, 0, 0, 0, '0, 0, 0);
        for (int i = 0; i < NW - 1; i++) cyc(0, 0, '0, 0, 1, 0, '0, 0, 0);
        check("R7 ring closed", XL'(cwp), '0);
        peek("R7 newest outs hit oldest ins", 25, 32'h0000_0C0C);

        // Random mix compared with the model every cycle
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 15));
            cyc($urandom_range(0, 1) == 1, int'($urandom_range(0, 31)), $urandom(),
                r == 0 || r == 2, r == 1 || r == 2,
                $urandom_range(0, 31) == 0, NW'($urandom() & $urandom()),
                int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule